// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous, pipelined static memory. Each rising clock edge captures an address, a select, a write enable and per-byte enables. On a write, the data and a late-select bit arrive one cycle after that address. The data is parked in a one-entry write buffer, and it reaches the storage array only when the next write comes along. On a read, the late-select bit from the following cycle picks one of the two words at the registered address. The chosen word is loaded into an output register on that same edge. Output enable and sleep act on the read port at once, without waiting for a clock.

The block takes one access per cycle and never stalls, so it has no back-pressure: there is no ready signal and no queue. Read data is marked by a drive flag rather than a valid/ready pair. When the flag is low the data pins read zero, which stands in for a released bus.

The organization is set by three parameters: the main address width, the data width and the lane count. For example, 18 address bits with 18 data bits and two lanes gives a 512K x 18 part, and 17 address bits with 36 data bits and four lanes gives a 256K x 36 part. The default is a small array.

Top module: `lwsram`

## Requirements
- R1: A read whose address phase is captured at edge t loads the output register at edge t+1, and its data is driven after that edge. In a cycle that captured no read, the output register keeps its value.
- R2: For a read, the late-select bit is sampled at the edge after the address. It selects word index addr*2+lsel, so lsel=0 picks the even word.
- R3: For a write, the data and the late-select bit are sampled one edge after the address and controls. The data is stored at word index addr*2+lsel.
- R4: Byte lane b covers bits [b*BYTE_W+BYTE_W-1 : b*BYTE_W], which is 9 bits per lane when the width is 18 with two lanes. A write updates only the lanes whose enable is 1, and a write with all enables at 0 leaves memory unchanged.
- R5: At most one write waits in the buffer. It is committed to the array at the data phase of the next write. Any read whose address phase comes after that write's address phase returns the pending data, merged lane by lane over the array contents.
- R6: While sel is 0, the address phase is a no-op. Nothing is written, and in the following cycle rdata_drv is 0 and rdata is zero.
- R7: While oe is 0, rdata_drv is 0 and rdata is zero at once, with no clock needed. Raising oe again restores the held read data.
- R8: While sleep is 1, the outputs are released at once and any access presented in that cycle is ignored. A write data phase already in flight still completes, and memory contents are kept.
- R9: After reset, rdata_drv is 0, rdata is zero and the write buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| sel | input | 1 | Synchronous select for the address phase |
| wr_en | input | 1 | Global write enable (1 = write, 0 = read) |
| byte_en | input | BYTES | Per-lane write enables, captured with the address |
| addr | input | ADDR_W | Main address of a word pair |
| lsel | input | 1 | Late-select bit, sampled one cycle after the address |
| wdata | input | DATA_W | Write data, sampled one cycle after the address |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; blocks new accesses |
| rdata | output | DATA_W | Read data; zero when not driven |
| rdata_drv | output | 1 | High when rdata is actively driven |

## Verification
The bench builds the block with ADDR_W=3, DATA_W=18 and BYTES=2, which gives sixteen words in two 9-bit lanes. At that size the sweeps can cover every word index, both late-select halves and all four lane-enable patterns.

Each sweep includes a write followed at once by a read of the same index, so the read finds its data still in the buffer. The bench also runs deselected cycles, sleep cycles and a mid-cycle output-enable drop against a model in the bench that applies writes in address-phase order.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lwsram_ctrl.sv
module lwsram_ctrl
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              sleep,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  byte_en,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BYTES-1:0]  be_q
);
  // Address phase register: an access is accepted only when selected and awake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      addr_q <= '0;
      be_q   <= '0;
    end else begin
      if (sel && !sleep) op_q <= wr_en ? OP_WRITE : OP_READ;
      else               op_q <= OP_NONE;
      addr_q <= addr;
      be_q   <= byte_en;
    end
  end
endmodule

// File: rtl/lwsram_wbuf.sv
module lwsram_wbuf #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 18,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [BYTES-1:0]  ld_be,
  input  logic [DATA_W-1:0] ld_data,
  output logic              vld,
  output logic [IDX_W-1:0]  idx,
  output logic [BYTES-1:0]  be,
  output logic [DATA_W-1:0] data,
  output logic              commit
);
  // The held entry is retired to the array on the same edge a newer write lands.
  assign commit = load && vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      idx  <= '0;
      be   <= '0;
      data <= '0;
    end else if (load) begin
      vld  <= 1'b1;
      idx  <= ld_idx;
      be   <= ld_be;
      data <= ld_data;
    end
  end
endmodule

// File: rtl/lwsram_array.sv
module lwsram_array #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 18,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [BYTES-1:0]  w_be,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int BYTE_W = DATA_W / BYTES;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BYTES; b++) begin
        if (w_be[b]) mem[w_idx][b*BYTE_W +: BYTE_W] <= w_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign r_data = mem[r_idx];
endmodule

// File: rtl/lwsram_out.sv
module lwsram_out #(
  parameter int IDX_W  = 9,
  parameter int DATA_W = 18,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              b_vld,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [BYTES-1:0]  b_be,
  input  logic [DATA_W-1:0] b_data,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv
);
  localparam int BYTE_W = DATA_W / BYTES;

  logic              hit;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] q_r;
  logic              live_r;

  assign hit = b_vld && (b_idx == r_idx);

  // Per-lane forwarding of the uncommitted write over the array word.
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign merged[g*BYTE_W +: BYTE_W] = (hit && b_be[g]) ? b_data[g*BYTE_W +: BYTE_W]
                                                         : arr_data[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      live_r <= 1'b0;
    end else begin
      live_r <= rd_go;
      if (rd_go) q_r <= merged;
    end
  end

  // Output enable and sleep gate the pins without a clock.
  assign rdata_drv = live_r && oe && !sleep;
  assign rdata     = rdata_drv ? q_r : '0;
endmodule

// File: rtl/lwsram.sv
module lwsram
  import lwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic [BYTES-1:0]  byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drv
);
  localparam int IDX_W = ADDR_W + 1;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTES-1:0]  be_q;
  logic [IDX_W-1:0]  cur_idx;
  logic              wb_vld;
  logic [IDX_W-1:0]  wb_idx;
  logic [BYTES-1:0]  wb_be;
  logic [DATA_W-1:0] wb_data;
  logic              wb_commit;
  logic [DATA_W-1:0] arr_q;

  // Late select completes the word index one cycle after the main address.
  assign cur_idx = {addr_q, lsel};

  lwsram_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .sleep(sleep),
    .addr(addr), .byte_en(byte_en), .op_q(op_q), .addr_q(addr_q), .be_q(be_q)
  );

  lwsram_wbuf #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .load(op_q == OP_WRITE), .ld_idx(cur_idx),
    .ld_be(be_q), .ld_data(wdata), .vld(wb_vld), .idx(wb_idx), .be(wb_be),
    .data(wb_data), .commit(wb_commit)
  );

  lwsram_array #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_array (
    .clk(clk), .we(wb_commit), .w_idx(wb_idx), .w_be(wb_be), .w_data(wb_data),
    .r_idx(cur_idx), .r_data(arr_q)
  );

  lwsram_out #(.IDX_W(IDX_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_go(op_q == OP_READ), .r_idx(cur_idx),
    .arr_data(arr_q), .b_vld(wb_vld), .b_idx(wb_idx), .b_be(wb_be), .b_data(wb_data),
    .oe(oe), .sleep(sleep), .rdata(rdata), .rdata_drv(rdata_drv)
  );
endmodule

// File: rtl/lwsram_chk.sv
module lwsram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr_en,
  input logic              sleep,
  input logic              oe,
  input logic              rdata_drv,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] q,
  input logic              commit,
  input logic              buf_vld
);
  // R1
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr_en && !sleep) |=> ##1 (rdata_drv == (oe && !sleep)));

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && !wr_en && !sleep) |=> ##1 $stable(q));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || sleep) |=> ##1 !rdata_drv);

  // R8
  no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel || sleep) |=> !commit);

  // R5
  buf_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_vld) |-> $past(sel && wr_en && !sleep, 2));

  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!rdata_drv && rdata == '0));
endmodule

bind lwsram lwsram_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .sleep(sleep), .oe(oe),
  .rdata_drv(rdata_drv), .rdata(rdata), .q(u_out.q_r), .commit(wb_commit),
  .buf_vld(wb_vld)
);

// File: tb/lwsram_tb.sv
module lwsram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW    = 3;
  localparam int DW    = 18;
  localparam int NB    = 2;
  localparam int BW    = DW / NB;
  localparam int NW    = 1 << (AW + 1);

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n, sel, wr_en, lsel, oe, sleep, rdata_drv;
  logic [NB-1:0] byte_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  lwsram #(.ADDR_W(AW), .DATA_W(DW), .BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .byte_en(byte_en),
    .addr(addr), .lsel(lsel), .wdata(wdata), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdata_drv(rdata_drv)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] ref_mem [NW];

  bit            p_act, p_wr, p_ls;
  int            p_addr;
  logic [NB-1:0] p_be;
  logic [DW-1:0] p_wd;
  string         p_tag;
  bit            e_rd;
  logic [DW-1:0] e_val;
  string         e_tag;

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    logic          d;
    logic [DW-1:0] v;
    d = e_rd && oe && !sleep;
    v = d ? e_val : {DW{1'b0}};
    check(e_tag, {rdata_drv, rdata}, {d, v});
  endtask

  // One cycle: check the access issued two cycles ago, give the late fields of
  // the previous access, then present a new address phase.
  task automatic op(input bit s, input bit w, input int a, input logic [NB-1:0] be,
                    input bit ls, input logic [DW-1:0] wd, input bit slp, input string tag);
    int idx;
    check_out();
    lsel  = p_ls;
    wdata = p_wd;
    idx   = p_addr * 2 + int'(p_ls);
    e_rd  = 1'b0;
    e_tag = p_tag;
    if (p_act && p_wr) begin
      for (int b = 0; b < NB; b++)
        if (p_be[b]) ref_mem[idx][b*BW +: BW] = p_wd[b*BW +: BW];
    end else if (p_act) begin
      e_rd  = 1'b1;
      e_val = ref_mem[idx];
    end
    sel     = s;
    wr_en   = w;
    addr    = a[AW-1:0];
    byte_en = be;
    sleep   = slp;
    p_act   = s && !slp;
    p_wr    = w;
    p_addr  = a;
    p_be    = be;
    p_ls    = ls;
    p_wd    = wd;
    p_tag   = tag;
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] fill_val(input int i);
    int t;
    t = i * 24593 + 1234;
    return t[DW-1:0];
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0; sel = 1'b0; wr_en = 1'b0; lsel = 1'b0; oe = 1'b1; sleep = 1'b0;
    byte_en = '0; addr = '0; wdata = '0;
    p_act = 1'b0; p_wr = 1'b0; p_ls = 1'b0; p_addr = 0; p_be = '0; p_wd = '0;
    p_tag = "R6 idle"; e_rd = 1'b0; e_val = '0; e_tag = "R9 after reset";
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {rdata_drv, rdata}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: fill every word, back to back
    for (int i = 0; i < NW; i++) op(1, 1, i >> 1, 2'b11, i[0], fill_val(i), 0, "R3 write");
    // R1/R2: read every word, back to back
    for (int i = 0; i < NW; i++) op(1, 0, i >> 1, 2'b00, i[0], '0, 0, "R1/R2 read");

    // R4/R5: partial write then immediate read of the same and the sibling word
    for (int i = 0; i < NW; i++) begin
      for (int be = 0; be < 4; be++) begin
        t = i * 911 + be * 7777 + 5;
        op(1, 1, i >> 1, be[NB-1:0], i[0], t[DW-1:0], 0, "R4 write");
        op(1, 0, i >> 1, 2'b00, i[0], '0, 0, "R5 forward");
        op(1, 0, i >> 1, 2'b00, ~i[0], '0, 0, "R2 sibling");
      end
    end

    // R6: deselected writes change nothing
    for (int i = 0; i < NW; i++) op(0, 1, i >> 1, 2'b11, i[0], ~fill_val(i), 0, "R6 deselect");
    for (int i = 0; i < NW; i++) op(1, 0, i >> 1, 2'b00, i[0], '0, 0, "R6 readback");

    // R8: sleep releases outputs and blocks accesses
    op(1, 0, 0, 2'b00, 1'b0, '0, 0, "R8 read before sleep");
    op(1, 1, 1, 2'b11, 1'b0, 18'h2aaaa, 1, "R8 sleep write");
    op(1, 1, 2, 2'b11, 1'b1, 18'h15555, 1, "R8 sleep write");
    op(0, 0, 0, 2'b00, 1'b0, '0, 0, "R8 wake");
    for (int i = 0; i < NW; i++) op(1, 0, i >> 1, 2'b00, i[0], '0, 0, "R8 readback");

    // R7: output enable drop between clock edges
    op(1, 0, 3, 2'b00, 1'b1, '0, 0, "R7 held data");
    op(0, 0, 0, 2'b00, 1'b0, '0, 0, "R6 idle");
    oe = 1'b0;
    #1;
    check("R7 oe low", {rdata_drv, rdata}, '0);
    oe = 1'b1;
    #1;
    op(0, 0, 0, 2'b00, 1'b0, '0, 0, "R6 idle");

    repeat (3) op(0, 0, 0, 2'b00, 1'b0, '0, 0, "R6 drain");
    report();
    $finish;
  end
endmodule